// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces data memory addresses from a bank of eight pointer registers. Every pointer comes with three companion registers: a signed modify step, a buffer length and a buffer base. When an access is requested, the selected pointer is presented as the address on the next cycle. In the same cycle the pointer is post-modified, either by its own modify register or by an immediate step that comes with the request. A nonzero length turns the pointer into a circular buffer that wraps inside `[base, base + length)`. A zero length gives plain linear stepping.

Every register exists in two copies, primary and alternate, so that an interrupt handler can switch context without saving anything. Two select inputs, normally driven from a mode control register, pick the live copy. One input covers pointer sets 0 to 3 and the other covers sets 4 to 7, so one half can change context while values in the other half remain shared. A register port writes and reads whichever copy is live, so the surrounding sequencer can set up buffers.

Top module: `circ_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, every register in both copies reads as zero, `addr_valid` is low, and the primary copy (select = 0) is live.
- R2: `addr_valid` is high exactly in the cycle after a cycle with `req_valid` high. `addr_out` then holds the live pointer value from before the update.
- R3: `req_use_imm` = 0 steps the pointer by its live modify register. `req_use_imm` = 1 steps it by `req_imm`. Both steps are read as two's-complement signed values.
- R4: With a length of zero, the new pointer is pointer + step modulo 2^32.
- R5: With a nonzero length, a sum at or above base + length has the length subtracted from it.
- R6: With a nonzero length, a sum below base has the length added to it.
- R7: `sel_lo` chooses the copy for indices 0–3 and `sel_hi` chooses it for indices 4–7 (0 = primary, 1 = alternate). Writes, post-modifies and reads touch only the live copy.
- R8: Changing one select bit leaves the registers of the other half visible and unchanged.
- R9: A register-port write to the pointer that is being post-modified in the same cycle takes priority over the post-modify.
- R10: `rd_data` combinationally shows the live register chosen by `rd_idx` and `rd_kind` (0 = pointer, 1 = modify, 2 = length, 3 = base). `wr_kind` uses the same encoding.
- R11: Without a request or a write, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_lo | input | 1 | Copy select for pointer sets 0–3 |
| sel_hi | input | 1 | Copy select for pointer sets 4–7 |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register kind to write |
| wr_idx | input | 3 | Pointer set index to write |
| wr_data | input | 32 | Write value |
| rd_kind | input | 2 | Register kind to read |
| rd_idx | input | 3 | Pointer set index to read |
| rd_data | output | 32 | Live register value |
| req_valid | input | 1 | Access request |
| req_idx | input | 3 | Pointer used by the request |
| req_use_imm | input | 1 | Step from `req_imm` instead of the modify register |
| req_imm | input | 32 | Signed immediate step |
| addr_valid | output | 1 | Address valid |
| addr_out | output | 32 | Pre-modify pointer value |

## Verification
The range assertion relies on two conditions for a circular pointer: the pointer starts inside its buffer, and the step magnitude is no larger than the length. Outside these conditions a single wrap cannot bring the pointer back into range. In the randomized phase the stimulus keeps to them. It loads every pointer at a position inside its buffer. It draws each immediate or modify value from `[-length, +length]` of the pointer it targets. During that phase it writes only modify registers, never pointers. The directed phases place sums exactly on both buffer edges.

// File: rtl/cag_pkg.sv
// Shared definitions for the circular buffer address generator.
// Assumes two register copies per pointer set and four register kinds.
package cag_pkg;

    // Register kind selector used by the write and read ports.
    typedef enum logic [1:0] {
        RK_PTR  = 2'd0,
        RK_MOD  = 2'd1,
        RK_LEN  = 2'd2,
        RK_BASE = 2'd3
    } reg_kind_e;

    localparam int unsigned NUM_KINDS  = 4;
    localparam int unsigned NUM_COPIES = 2;

endpackage

// File: rtl/cag_copy_sel.sv
// Maps the two select bits to a live-copy bit for each pointer set.
// Assumes NPTR is even; the lower half follows sel_lo and the upper half follows sel_hi.
module cag_copy_sel #(
    parameter int NPTR = 8
) (
    input  logic            sel_lo,
    input  logic            sel_hi,
    output logic [NPTR-1:0] live_alt
);
    localparam int HALF = NPTR / 2;

    // One live-copy bit per pointer set, chosen by the half it belongs to.
    for (genvar p = 0; p < NPTR; p++) begin : g_live
        if (p < HALF) begin : g_low
            assign live_alt[p] = sel_lo;
        end else begin : g_high
            assign live_alt[p] = sel_hi;
        end
    end
endmodule

// File: rtl/cag_modulo.sv
// Post-modify arithmetic: pointer plus a signed step, with at most one
// wrap into [base, base+len) when len is nonzero.
// Assumes |step| <= len and a pointer inside its buffer for a correct circular result.
module cag_modulo #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] len,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] nxt
);
    localparam int XW = AW + 2;

    logic signed [XW-1:0] sum_x;
    logic signed [XW-1:0] top_x;
    logic signed [XW-1:0] base_x;
    logic signed [XW-1:0] len_x;
    logic signed [XW-1:0] res_x;

    // Extend operands so that carries and borrows stay visible.
    always_comb begin
        sum_x  = $signed({2'b00, ptr}) + $signed({{2{step[AW-1]}}, step});
        base_x = $signed({2'b00, base});
        len_x  = $signed({2'b00, len});
        top_x  = base_x + len_x;
    end

    // Choose between the linear sum and a single wrap in either direction.
    always_comb begin
        res_x = sum_x;
        if (len != '0) begin
            if (sum_x >= top_x) begin
                res_x = sum_x - len_x;
            end else if (sum_x < base_x) begin
                res_x = sum_x + len_x;
            end
        end
        nxt = res_x[AW-1:0];
    end
endmodule

// File: rtl/cag_regbank.sv
// Holds the pointer, modify, length and base registers for both copies.
// A register-port write is applied after the post-modify, so it wins on a clash.
// Assumes indices below NPTR; each access touches only the live copy.
module cag_regbank
    import cag_pkg::*;
#(
    parameter int NPTR = 8,
    parameter int AW   = 32,
    parameter int IW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPTR-1:0] live_alt,
    input  logic            wr_en,
    input  reg_kind_e       wr_kind,
    input  logic [IW-1:0]   wr_idx,
    input  logic [AW-1:0]   wr_data,
    input  logic            upd_en,
    input  logic [IW-1:0]   upd_idx,
    input  logic [AW-1:0]   upd_val,
    input  logic [IW-1:0]   q_idx,
    output logic [AW-1:0]   q_ptr,
    output logic [AW-1:0]   q_mod,
    output logic [AW-1:0]   q_len,
    output logic [AW-1:0]   q_base,
    input  reg_kind_e       rd_kind,
    input  logic [IW-1:0]   rd_idx,
    output logic [AW-1:0]   rd_data
);
    logic [AW-1:0] regs_q [NUM_COPIES][NPTR][NUM_KINDS];

    // Clear all copies on reset, then apply the post-modify and the (higher priority) write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < int'(NUM_COPIES); c++) begin
                for (int p = 0; p < NPTR; p++) begin
                    for (int k = 0; k < int'(NUM_KINDS); k++) begin
                        regs_q[c][p][k] <= '0;
                    end
                end
            end
        end else begin
            if (upd_en) begin
                regs_q[live_alt[upd_idx]][upd_idx][RK_PTR] <= upd_val;
            end
            if (wr_en) begin
                regs_q[live_alt[wr_idx]][wr_idx][wr_kind] <= wr_data;
            end
        end
    end

    // Live-copy view of the set addressed by the request.
    always_comb begin
        q_ptr  = regs_q[live_alt[q_idx]][q_idx][RK_PTR];
        q_mod  = regs_q[live_alt[q_idx]][q_idx][RK_MOD];
        q_len  = regs_q[live_alt[q_idx]][q_idx][RK_LEN];
        q_base = regs_q[live_alt[q_idx]][q_idx][RK_BASE];
    end

    // Live-copy view for the register read port.
    always_comb begin
        rd_data = regs_q[live_alt[rd_idx]][rd_idx][rd_kind];
    end
endmodule

// File: rtl/circ_addr_gen.sv
// Top of the circular buffer address generator. On a request it registers
// the live pointer as the address and writes back the post-modified pointer.
// Assumes the select bits are steady around a request; their value in the request cycle applies.
module circ_addr_gen
    import cag_pkg::*;
#(
    parameter  int NPTR = 8,
    parameter  int AW   = 32,
    localparam int IW   = $clog2(NPTR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_lo,
    input  logic          sel_hi,
    input  logic          wr_en,
    input  logic [1:0]    wr_kind,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic [1:0]    rd_kind,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_data,
    input  logic          req_valid,
    input  logic [IW-1:0] req_idx,
    input  logic          req_use_imm,
    input  logic [AW-1:0] req_imm,
    output logic          addr_valid,
    output logic [AW-1:0] addr_out
);
    logic [NPTR-1:0] live_alt;
    logic [AW-1:0]   q_ptr;
    logic [AW-1:0]   q_mod;
    logic [AW-1:0]   q_len;
    logic [AW-1:0]   q_base;
    logic [AW-1:0]   mod_val;
    logic [AW-1:0]   nxt_ptr;

    cag_copy_sel #(.NPTR(NPTR)) u_copy_sel (
        .sel_lo   (sel_lo),
        .sel_hi   (sel_hi),
        .live_alt (live_alt)
    );

    cag_regbank #(.NPTR(NPTR), .AW(AW), .IW(IW)) u_regbank (
        .clk      (clk),
        .rst_n    (rst_n),
        .live_alt (live_alt),
        .wr_en    (wr_en),
        .wr_kind  (reg_kind_e'(wr_kind)),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .upd_en   (req_valid),
        .upd_idx  (req_idx),
        .upd_val  (nxt_ptr),
        .q_idx    (req_idx),
        .q_ptr    (q_ptr),
        .q_mod    (q_mod),
        .q_len    (q_len),
        .q_base   (q_base),
        .rd_kind  (reg_kind_e'(rd_kind)),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data)
    );

    // Choose the step source for the post-modify.
    always_comb begin
        mod_val = req_use_imm ? req_imm : q_mod;
    end

    cag_modulo #(.AW(AW)) u_modulo (
        .ptr  (q_ptr),
        .step (mod_val),
        .len  (q_len),
        .base (q_base),
        .nxt  (nxt_ptr)
    );

    // Register the pre-modify pointer as the output address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_valid <= 1'b0;
            addr_out   <= '0;
        end else begin
            addr_valid <= req_valid;
            if (req_valid) begin
                addr_out <= q_ptr;
            end
        end
    end
endmodule

// File: rtl/cag_checker.sv
// Property checker for circ_addr_gen, attached with bind. It watches the
// ports together with the request-side register view and the modulo result.
module cag_checker #(
    parameter  int NPTR = 8,
    parameter  int AW   = 32,
    localparam int IW   = $clog2(NPTR)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel_lo,
    input logic          sel_hi,
    input logic          wr_en,
    input logic [1:0]    rd_kind,
    input logic [IW-1:0] rd_idx,
    input logic [AW-1:0] rd_data,
    input logic          req_valid,
    input logic          addr_valid,
    input logic [AW-1:0] addr_out,
    input logic [AW-1:0] q_ptr,
    input logic [AW-1:0] q_len,
    input logic [AW-1:0] q_base,
    input logic [AW-1:0] mod_val,
    input logic [AW-1:0] nxt_ptr
);
    localparam int XW = AW + 2;

    logic signed [XW-1:0] p_x, m_x, b_x, l_x, n_x, mag_x;
    logic                 in_buf;
    logic                 step_ok;

    // Helper terms for the range property, in widened signed form.
    always_comb begin
        p_x     = $signed({2'b00, q_ptr});
        m_x     = $signed({{2{mod_val[AW-1]}}, mod_val});
        b_x     = $signed({2'b00, q_base});
        l_x     = $signed({2'b00, q_len});
        n_x     = $signed({2'b00, nxt_ptr});
        mag_x   = (m_x < 0) ? -m_x : m_x;
        in_buf  = (q_len != '0) && (p_x >= b_x) && (p_x < b_x + l_x);
        step_ok = (mag_x <= l_x);
    end

    // R2: a request gives a valid address of the pre-modify pointer next cycle.
    a_r2_addr_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (addr_valid && addr_out == $past(q_ptr)));

    // R2: no request, no valid address.
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !addr_valid);

    // R5, R6: a legal circular step lands inside the buffer.
    a_r5_r6_stays_in_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_buf && step_ok) |-> (n_x >= b_x && n_x < b_x + l_x));

    // R4: zero length gives a plain sum modulo 2^AW.
    a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && q_len == '0) |-> (nxt_ptr == AW'(q_ptr + mod_val)));

    // R11: with no request and no write, a steady read selection sees a steady value.
    a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !wr_en) ##1 ($stable(rd_idx) && $stable(rd_kind)
            && $stable(sel_lo) && $stable(sel_hi)) |-> $stable(rd_data));
endmodule

bind circ_addr_gen cag_checker #(.NPTR(NPTR), .AW(AW)) u_cag_checker (.*);

// File: tb/circ_addr_gen_bench.sv
module circ_addr_gen_bench;
    localparam int NPTR = 8;
    localparam int AW   = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sel_lo, sel_hi;
    logic        wr_en;
    logic [1:0]  wr_kind;
    logic [2:0]  wr_idx;
    logic [31:0] wr_data;
    logic [1:0]  rd_kind;
    logic [2:0]  rd_idx;
    logic [31:0] rd_data;
    logic        req_valid;
    logic [2:0]  req_idx;
    logic        req_use_imm;
    logic [31:0] req_imm;
    logic        addr_valid;
    logic [31:0] addr_out;

    always #4 clk = ~clk;

    circ_addr_gen u_circ_addr_gen (.*);

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";
    bit    done   = 1'b0;

    logic [31:0] mreg [2][8][4];
    logic        exp_valid;
    logic [31:0] exp_addr;

    function automatic int live(input logic [2:0] idx);
        return (idx < 4) ? int'(sel_lo) : int'(sel_hi);
    endfunction

    function automatic logic [31:0] step_model(input logic [31:0] p, m, b, l);
        longint s;
        s = longint'(p) + longint'($signed(m));
        if (l != 0) begin
            if (s >= longint'(b) + longint'(l)) s = s - longint'(l);
            else if (s < longint'(b)) s = s + longint'(l);
        end
        return s[31:0];
    endfunction

    task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 0; wr_kind = 0; wr_idx = 0; wr_data = 0;
        req_valid = 0; req_idx = 0; req_use_imm = 0; req_imm = 0;
    endtask

    // One clock: predict, clock, update the model, compare at the falling edge.
    task automatic tick();
        int          rc, wc;
        logic [31:0] np;
        logic        do_upd;
        rc = live(req_idx);
        wc = live(wr_idx);
        do_upd = req_valid;
        np = 0;
        if (req_valid) begin
            exp_addr = mreg[rc][req_idx][0];
            np = step_model(mreg[rc][req_idx][0],
                            req_use_imm ? req_imm : mreg[rc][req_idx][1],
                            mreg[rc][req_idx][3], mreg[rc][req_idx][2]);
        end
        exp_valid = req_valid;
        @(posedge clk);
        if (do_upd) mreg[rc][req_idx][0] = np;
        if (wr_en) mreg[wc][wr_idx][wr_kind] = wr_data;
        @(negedge clk);
        chk(addr_valid === exp_valid, "R2 addr_valid", 32'(addr_valid), 32'(exp_valid));
        if (exp_valid) chk(addr_out === exp_addr, tag, addr_out, exp_addr);
        chk(rd_data === mreg[live(rd_idx)][rd_idx][rd_kind], {tag, " rd_data"},
            rd_data, mreg[live(rd_idx)][rd_idx][rd_kind]);
    endtask

    task automatic wr(input int idx, input int kind, input logic [31:0] d);
        wr_en = 1; wr_idx = 3'(idx); wr_kind = 2'(kind); wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic acc(input int idx, input bit use_imm, input int imm);
        req_valid = 1; req_idx = 3'(idx); req_use_imm = use_imm; req_imm = 32'(imm);
        tick();
        req_valid = 0;
    endtask

    task automatic setup(input int idx, input logic [31:0] b, l, p, m);
        wr(idx, 3, b); wr(idx, 2, l); wr(idx, 0, p); wr(idx, 1, m);
    endtask

    task automatic look(input int idx, input int kind);
        rd_idx = 3'(idx); rd_kind = 2'(kind);
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; sel_lo = 0; sel_hi = 0; rd_idx = 0; rd_kind = 0;
        idle_inputs();
        exp_valid = 0; exp_addr = 0;
        for (int c = 0; c < 2; c++)
            for (int p = 0; p < 8; p++)
                for (int k = 0; k < 4; k++) mreg[c][p][k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: everything reads zero in both copies, no valid address.
        tag = "R1";
        chk(addr_valid === 1'b0, "R1 addr_valid", 32'(addr_valid), 0);
        for (int s = 0; s < 2; s++) begin
            sel_lo = s[0]; sel_hi = s[0];
            for (int p = 0; p < 8; p++)
                for (int k = 0; k < 4; k++) look(p, k);
        end
        sel_lo = 0; sel_hi = 0;

        // R10: register port read of each kind after writes.
        tag = "R10";
        setup(0, 32'd100, 32'd10, 32'd100, 32'd3);
        for (int k = 0; k < 4; k++) look(0, k);

        // R5: upward wrap, including a sum exactly at base+len.
        tag = "R5";
        rd_idx = 0; rd_kind = 0;
        for (int i = 0; i < 12; i++) acc(0, 0, 0);
        setup(1, 32'd50, 32'd4, 32'd52, 32'd2);
        rd_idx = 1;
        acc(1, 0, 0); acc(1, 0, 0); acc(1, 0, 0);

        // R6: downward wrap, including a sum one below base.
        tag = "R6";
        setup(2, 32'd200, 32'd8, 32'd201, 32'hFFFF_FFFD);
        rd_idx = 2;
        for (int i = 0; i < 6; i++) acc(2, 0, 0);
        acc(2, 1, -8); acc(2, 1, 8);

        // R4 and R3: linear stepping across the 2^32 boundary, register and immediate steps.
        tag = "R4";
        setup(5, 32'd0, 32'd0, 32'hFFFF_FFF0, 32'd5);
        rd_idx = 5;
        for (int i = 0; i < 5; i++) acc(5, 0, 0);
        tag = "R3";
        acc(5, 1, -7); acc(5, 1, 1000); acc(5, 0, 0); acc(5, 1, -1);

        // R7: alternate copy of the lower half is separate from the primary copy.
        tag = "R7";
        sel_lo = 1;
        look(0, 0);
        setup(0, 32'd500, 32'd6, 32'd503, 32'd4);
        rd_idx = 0;
        acc(0, 0, 0); acc(0, 0, 0); acc(0, 0, 0);
        sel_lo = 0;
        look(0, 0); look(0, 3);
        acc(0, 0, 0);

        // R8: upper half stays visible and unchanged while the lower select toggles.
        tag = "R8";
        sel_lo = 1;
        look(5, 0); look(5, 1);
        acc(5, 0, 0);
        sel_lo = 0;
        look(5, 0);
        sel_hi = 1;
        look(5, 0); look(2, 0);
        sel_hi = 0;
        look(5, 0);

        // R9: a write to the pointer being post-modified wins.
        tag = "R9";
        setup(3, 32'd64, 32'd16, 32'd70, 32'd2);
        rd_idx = 3; rd_kind = 0;
        req_valid = 1; req_idx = 3; req_use_imm = 0;
        wr_en = 1; wr_idx = 3; wr_kind = 0; wr_data = 32'd75;
        tick();
        idle_inputs();
        acc(3, 0, 0);
        look(3, 0);

        // R11: idle cycles change nothing and give no address.
        tag = "R11";
        for (int i = 0; i < 8; i++) look(i, 0);
        for (int i = 0; i < 4; i++) look(3, 0);

        // R7 R3 R5 R6: mixed traffic within legal step bounds.
        tag = "R7 mixed";
        for (int c = 0; c < 2; c++) begin
            sel_lo = c[0]; sel_hi = c[0];
            for (int p = 0; p < 8; p++)
                setup(p, 32'(p * 64 + c * 1024), 32'(16 + p),
                      32'(p * 64 + c * 1024 + p), (p % 2 == 1) ? 32'd3 : 32'hFFFF_FFFB);
        end
        for (int i = 0; i < 600; i++) begin
            int idx, len, sv;
            idx = int'($urandom % 8);
            len = 16 + idx;
            sv  = int'($urandom % 32'(2 * len + 1)) - len;
            sel_lo = $urandom % 2; sel_hi = $urandom % 2;
            rd_idx = 3'($urandom % 8); rd_kind = 2'($urandom % 4);
            if ($urandom % 5 == 0) begin
                int widx;
                widx = int'($urandom % 8);
                wr_en = 1; wr_idx = 3'(widx); wr_kind = 1;
                wr_data = 32'(int'($urandom % 32'(2 * (16 + widx) + 1)) - (16 + widx));
            end
            req_valid = ($urandom % 4) != 0;
            req_idx = 3'(idx); req_use_imm = $urandom % 2; req_imm = 32'(sv);
            tick();
            idle_inputs();
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule